// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a port I/O access of one, two or four bytes may proceed when the processor runs at a privilege level that needs the per-port permission bitmap. A caller pulses `start_i` with the port number, the access width and the cached task-segment descriptor (present flag, type, base, limit). The block first checks the descriptor and the width. If both are acceptable it fetches the 16-bit bitmap pointer stored inside the task segment, bounds-checks the bitmap location, fetches a 16-bit word of the bitmap and tests the bits that belong to the accessed ports.

Memory is reached through a plain request/response port: the block raises `mem_req_o` with an address and holds it until the memory answers with a one-cycle `mem_rvalid_i` carrying 16 bits of data. The bitmap word is always read as two bytes, so an access whose ports straddle a byte boundary is fully covered. The result is a one-cycle `done_o` with either `allow_o` or `fault_o`; a fault stands for a general-protection exception whose error code, on `err_code_o`, is zero.

Top module: `io_perm_check`

## Requirements
- R1: When `start_i` is accepted and the descriptor is not present, its 4-bit type is not 9, or its limit is below 103, the verdict is a fault in the next cycle and no memory request is made.
- R2: A width `size_i` other than 1, 2 or 4 gives a fault in the next cycle with no memory request.
- R3: Otherwise the first read is at address base + 0x66 (modulo 2^32); its 16-bit result is the bitmap pointer.
- R4: The bitmap byte offset is the pointer plus the port number shifted right by 3; if that offset plus 1 exceeds the limit the verdict is a fault and no second read is made.
- R5: Otherwise the second read is at base + offset (modulo 2^32); the word is shifted right by port[2:0], and the access is allowed only if the low `size_i` bits of the result are all zero, a fault otherwise.
- R6: `done_o` is high for exactly one cycle per accepted start, with exactly one of `allow_o` and `fault_o` high; `err_code_o` is zero.
- R7: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle and low in the cycle after; `start_i` while busy is ignored, and the inputs are captured at the accepted start.
- R8: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_rvalid_i`; `mem_rvalid_i` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a check (accepted when not busy) |
| port_i | input | 16 | I/O port number |
| size_i | input | 3 | Access width in bytes (1, 2 or 4) |
| seg_present_i | input | 1 | Task-segment descriptor present flag |
| seg_type_i | input | 4 | Task-segment descriptor type |
| seg_base_i | input | 32 | Task-segment base address |
| seg_limit_i | input | 32 | Task-segment limit |
| mem_req_o | output | 1 | Read request, held until answered |
| mem_addr_o | output | 32 | Read address |
| mem_rvalid_i | input | 1 | Read data valid (one cycle) |
| mem_rdata_i | input | 16 | Read data |
| busy_o | output | 1 | Check in progress or verdict presented |
| done_o | output | 1 | Verdict valid (one cycle) |
| allow_o | output | 1 | Access permitted |
| fault_o | output | 1 | Access refused (general protection) |
| err_code_o | output | 16 | Error code reported with a fault |

## Verification
A corrupted captured port number or width shows at the ports as a wrong second read address or a wrong verdict on the very same check, one read later. A sequencer stuck in a read state shows as `mem_req_o` never dropping and `done_o` never rising, so the next expected verdict is missed within a few cycles of the final answer. Stimulus mixes random descriptors, pointers, limits and bitmap words with directed limits at 102/103, offsets exactly at and one past the limit, port numbers ending in 7 with width 4, bases that wrap, and start pulses and stray read-valid pulses injected while the block is busy or idle.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PTR,
    ST_MAP,
    ST_DONE
  } chk_state_e;

  localparam int MASK_W = 4;

endpackage

// File: rtl/io_perm_gate.sv
// Up-front screening of the descriptor and the access width.
module io_perm_gate import io_perm_pkg::*; #(
  parameter int LIMIT_W   = 32,
  parameter int TYPE_W    = 4,
  parameter int SEG_TYPE  = 9,
  parameter int MIN_LIMIT = 103
) (
  input  logic               present_i,
  input  logic [TYPE_W-1:0]  type_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic [2:0]         size_i,
  output logic               ok_o,
  output logic [MASK_W-1:0]  mask_o
);

  logic desc_ok;
  logic size_ok;

  always_comb begin
    desc_ok = present_i && (type_i == TYPE_W'(SEG_TYPE)) &&
              (limit_i >= LIMIT_W'(MIN_LIMIT));
    size_ok = 1'b1;
    case (size_i)
      3'd1:    mask_o = 4'b0001;
      3'd2:    mask_o = 4'b0011;
      3'd4:    mask_o = 4'b1111;
      default: begin
        mask_o  = 4'b0000;
        size_ok = 1'b0;
      end
    endcase
    ok_o = desc_ok && size_ok;
  end

endmodule

// File: rtl/io_perm_bound.sv
// Bitmap byte offset and the two-byte bounds test.
module io_perm_bound #(
  parameter int DATA_W  = 16,
  parameter int PORT_W  = 16,
  parameter int LIMIT_W = 32,
  localparam int OFF_W  = DATA_W + 1,
  localparam int HI_W   = PORT_W - 3,
  localparam int CMP_W  = LIMIT_W + 1
) (
  input  logic [DATA_W-1:0]  ptr_i,
  input  logic [HI_W-1:0]    port_hi_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic [OFF_W-1:0]   off_o,
  output logic               over_o
);

  logic [CMP_W-1:0] last_byte;

  always_comb begin
    off_o     = {1'b0, ptr_i} + {{(OFF_W - HI_W){1'b0}}, port_hi_i};
    last_byte = CMP_W'(off_o) + CMP_W'(1);
    over_o    = last_byte > {1'b0, limit_i};
  end

endmodule

// File: rtl/io_perm_bit_test.sv
// Shift the bitmap word to the first port and test the width's bits.
module io_perm_bit_test import io_perm_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [2:0]        shift_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              clear_o
);

  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = word_i >> shift_i;
    clear_o = (shifted & {{(DATA_W - MASK_W){1'b0}}, mask_i}) == '0;
  end

endmodule

// File: rtl/io_perm_check.sv
module io_perm_check import io_perm_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int PORT_W    = 16,
  parameter int DATA_W    = 16,
  parameter int TYPE_W    = 4,
  parameter int ERR_W     = 16,
  parameter int SEG_TYPE  = 9,
  parameter int MIN_LIMIT = 103,
  parameter int PTR_OFS   = 'h66,
  localparam int LIMIT_W  = ADDR_W,
  localparam int OFF_W    = DATA_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PORT_W-1:0]  port_i,
  input  logic [2:0]         size_i,
  input  logic               seg_present_i,
  input  logic [TYPE_W-1:0]  seg_type_i,
  input  logic [ADDR_W-1:0]  seg_base_i,
  input  logic [LIMIT_W-1:0] seg_limit_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               allow_o,
  output logic               fault_o,
  output logic [ERR_W-1:0]   err_code_o
);

  chk_state_e         state_q, state_d;
  logic [PORT_W-1:0]  port_q;
  logic [MASK_W-1:0]  mask_q;
  logic [ADDR_W-1:0]  base_q;
  logic [LIMIT_W-1:0] limit_q;
  logic [OFF_W-1:0]   off_q;
  logic               allow_q, allow_d;

  logic               gate_ok;
  logic [MASK_W-1:0]  gate_mask;
  logic [OFF_W-1:0]   map_off;
  logic               map_over;
  logic               bits_clear;

  io_perm_gate #(
    .LIMIT_W  (LIMIT_W),
    .TYPE_W   (TYPE_W),
    .SEG_TYPE (SEG_TYPE),
    .MIN_LIMIT(MIN_LIMIT)
  ) u_gate (
    .present_i(seg_present_i),
    .type_i   (seg_type_i),
    .limit_i  (seg_limit_i),
    .size_i   (size_i),
    .ok_o     (gate_ok),
    .mask_o   (gate_mask)
  );

  io_perm_bound #(
    .DATA_W (DATA_W),
    .PORT_W (PORT_W),
    .LIMIT_W(LIMIT_W)
  ) u_bound (
    .ptr_i    (mem_rdata_i),
    .port_hi_i(port_q[PORT_W-1:3]),
    .limit_i  (limit_q),
    .off_o    (map_off),
    .over_o   (map_over)
  );

  io_perm_bit_test #(
    .DATA_W(DATA_W)
  ) u_bits (
    .word_i (mem_rdata_i),
    .shift_i(port_q[2:0]),
    .mask_i (mask_q),
    .clear_o(bits_clear)
  );

  always_comb begin
    state_d = state_q;
    allow_d = allow_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        allow_d = 1'b0;
        state_d = gate_ok ? ST_PTR : ST_DONE;
      end
      ST_PTR: if (mem_rvalid_i) begin
        allow_d = 1'b0;
        state_d = map_over ? ST_DONE : ST_MAP;
      end
      ST_MAP: if (mem_rvalid_i) begin
        allow_d = bits_clear;
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      port_q  <= '0;
      mask_q  <= '0;
      base_q  <= '0;
      limit_q <= '0;
      off_q   <= '0;
      allow_q <= 1'b0;
    end else begin
      state_q <= state_d;
      allow_q <= allow_d;
      if (state_q == ST_IDLE && start_i) begin
        port_q  <= port_i;
        mask_q  <= gate_mask;
        base_q  <= seg_base_i;
        limit_q <= seg_limit_i;
      end
      if (state_q == ST_PTR && mem_rvalid_i) off_q <= map_off;
    end
  end

  assign mem_req_o  = (state_q == ST_PTR) || (state_q == ST_MAP);
  assign mem_addr_o = base_q + ((state_q == ST_MAP) ? ADDR_W'(off_q) : ADDR_W'(PTR_OFS));
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign allow_o    = done_o && allow_q;
  assign fault_o    = done_o && !allow_q;
  assign err_code_o = '0;

  // R8: request and address held until answered
  a_r8_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R6: verdict lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6: exactly one verdict flag
  a_r6_one_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (allow_o ^ fault_o));

  // R7: busy drops after the verdict
  a_r7_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R1: bad descriptor never reaches memory
  a_r1_no_read_bad_desc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !seg_present_i) |=> (done_o && fault_o && !mem_req_o));

  // R8: stray valid while idle leaves the block idle
  a_r8_idle_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && mem_rvalid_i) |=> !busy_o);

endmodule

// File: tb/io_perm_check_bench.sv
`timescale 1ns/1ps
module io_perm_check_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] port_i = '0;
  logic [2:0]  size_i = '0;
  logic        seg_present_i = 1'b0;
  logic [3:0]  seg_type_i = '0;
  logic [31:0] seg_base_i = '0;
  logic [31:0] seg_limit_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;
  logic        busy_o, done_o, allow_o, fault_o;
  logic [15:0] err_code_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  io_perm_check u_io_perm_check (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input bit pres, input logic [3:0] typ,
      input logic [31:0] lim, input logic [15:0] port, input logic [2:0] sz,
      input logic [15:0] ptr, input logic [15:0] word,
      output bit allow, output int nrd, output logic [31:0] off, output string req);
    longint o;
    logic [15:0] w;
    logic [15:0] m;
    allow = 0; nrd = 0; off = 0;
    if (!(pres && typ == 4'd9 && lim >= 32'd103)) begin req = "R1"; return; end
    if (!(sz == 1 || sz == 2 || sz == 4)) begin req = "R2"; return; end
    o = longint'(ptr) + longint'(port >> 3);
    off = 32'(o);
    nrd = 1;
    if (o + 1 > longint'(lim)) begin req = "R4"; return; end
    nrd = 2;
    w = word >> port[2:0];
    m = 16'((1 << sz) - 1);
    allow = ((w & m) == 0);
    req = "R5";
  endfunction

  task automatic run(input bit pres, input logic [3:0] typ, input logic [31:0] base,
      input logic [31:0] lim, input logic [15:0] port, input logic [2:0] sz,
      input logic [15:0] ptr, input logic [15:0] word, input int lat, input bit noise);
    bit e_allow, got;
    int e_nrd, n_rd;
    logic [31:0] e_off, e_addr;
    string req;
    model(pres, typ, lim, port, sz, ptr, word, e_allow, e_nrd, e_off, req);
    @(negedge clk_i);
    seg_present_i = pres; seg_type_i = typ; seg_base_i = base; seg_limit_i = lim;
    port_i = port; size_i = sz; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // scramble inputs: they must have been captured (R7)
    port_i = 16'($urandom); size_i = 3'($urandom); seg_base_i = $urandom;
    seg_limit_i = $urandom; seg_present_i = 1'($urandom);
    n_rd = 0; got = 0;
    for (int cyc = 0; cyc < 64 && !got; cyc++) begin
      if (done_o) begin
        got = 1;
        chk(allow_o == e_allow, req, "allow", allow_o, e_allow);
        chk(fault_o == !e_allow, "R6", "fault", fault_o, !e_allow);
        chk(err_code_o == 16'h0, "R6", "err_code", err_code_o, 0);
        chk(n_rd == e_nrd, req, "reads", n_rd, e_nrd);
        chk(busy_o, "R7", "busy in verdict", busy_o, 1);
      end else if (mem_req_o) begin
        n_rd++;
        e_addr = (n_rd == 1) ? base + 32'h66 : base + e_off;
        chk(mem_addr_o == e_addr, (n_rd == 1) ? "R3" : "R5", "addr", mem_addr_o, e_addr);
        chk(busy_o, "R7", "busy with req", busy_o, 1);
        for (int k = 0; k < lat; k++) begin
          if (noise && k == 0) start_i = 1'b1;
          @(negedge clk_i);
          start_i = 1'b0;
        end
        if (lat > 0)
          chk(mem_req_o && mem_addr_o == e_addr, "R8", "held addr", mem_addr_o, e_addr);
        mem_rvalid_i = 1'b1;
        mem_rdata_i = (n_rd == 1) ? ptr : word;
        @(negedge clk_i);
        mem_rvalid_i = 1'b0;
        mem_rdata_i = 16'($urandom);
      end else begin
        @(negedge clk_i);
      end
    end
    chk(got, req, "verdict seen", got, 1);
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R7", "idle after verdict", busy_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1c0f));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o, "R7", "reset state", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R8: stray valid while idle
    mem_rvalid_i = 1'b1; mem_rdata_i = 16'h0;
    @(negedge clk_i);
    mem_rvalid_i = 1'b0;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o, "R8", "stray rvalid", busy_o, 0);
    // directed corners
    run(1, 9, 32'h1000, 32'd103, 16'h0000, 1, 16'h0068, 16'h0000, 0, 0); // R1 limit 103 ok, R4 fault
    run(1, 9, 32'h1000, 32'd102, 16'h0000, 1, 16'h0000, 16'h0000, 0, 0); // R1 limit 102
    run(1, 11, 32'h1000, 32'd200, 16'h0000, 1, 16'h0000, 16'h0000, 0, 0); // R1 type
    run(0, 9, 32'h1000, 32'd200, 16'h0000, 1, 16'h0000, 16'h0000, 0, 0); // R1 absent
    run(1, 9, 32'h1000, 32'd200, 16'h0010, 3, 16'h0000, 16'h0000, 0, 0); // R2 size 3
    run(1, 9, 32'h1000, 32'd200, 16'h0010, 0, 16'h0000, 16'h0000, 0, 0); // R2 size 0
    run(1, 9, 32'h2000, 32'd200, 16'h0008, 1, 16'd198, 16'h0000, 1, 0);  // R4 off+1 == limit: allow
    run(1, 9, 32'h2000, 32'd200, 16'h0010, 1, 16'd198, 16'h0000, 1, 0);  // R4 off+1 > limit
    run(1, 9, 32'h2000, 32'd300, 16'h0007, 4, 16'd100, 16'h0400, 2, 0);  // R5 crossing, bit 10 -> fault
    run(1, 9, 32'h2000, 32'd300, 16'h0007, 4, 16'd100, 16'h0800, 2, 0);  // R5 bit 11 outside -> allow
    run(1, 9, 32'h2000, 32'd300, 16'h0005, 2, 16'd100, 16'h0040, 0, 1);  // R5 second bit set
    run(1, 9, 32'hFFFF_FFF0, 32'hFFFF, 16'h0100, 1, 16'h0100, 16'h0000, 1, 1); // R3 wrap
    // random
    for (int i = 0; i < 400; i++) begin
      logic [15:0] p, ptr;
      logic [31:0] lim;
      int pick;
      p = 16'($urandom);
      ptr = 16'($urandom);
      pick = $urandom % 4;
      case (pick)
        0: lim = 32'($urandom % 300);
        1: lim = 32'(ptr) + 32'(p >> 3) + 32'($urandom % 3) - 1;
        2: lim = 32'hFFFF_FFFF;
        default: lim = $urandom;
      endcase
      run(($urandom % 8) != 0, (($urandom % 6) == 0) ? 4'($urandom) : 4'd9, $urandom, lim, p,
          (($urandom % 6) == 0) ? 3'($urandom) : 3'(1 << ($urandom % 3)),
          ptr, 16'($urandom & $urandom & $urandom), $urandom % 4, 1'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule